// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block sits on the read path of an embedded flash array. While the array is idle, it hands back the array word unchanged. While a program or erase operation runs, or a sector erase is suspended, it replaces the returned half-word with a status byte. The status byte reports progress through a data-poll bit, two toggle bits, a time-limit bit and an erase-timer bit. Software finds out whether the operation has finished by polling any array address and watching these bits.

The command decoder drives the block. It supplies the operation state, the half-word being programmed, a mask of the sectors chosen for erase, a time-limit indication, a one-cycle pulse when an operation starts, and a one-cycle pulse on every command write. Each accepted read strobe produces one registered result a cycle later. Each result carries a marker for reads whose value is not guaranteed. The toggle bits are driven by read history: they flip only on accepted reads. Whether the addressed sector is an erase target decides what a suspended read returns.

Top module: `flash_status_gen`

## Requirements
- R1: With op_state = 0 (idle), a read returns the 16-bit array word presented with the strobe. Outside suspend, the upper byte and bits 4, 1 and 0 are always 0 in the status word.
- R2: rd_valid is 1 exactly in the cycle after a cycle with rd_en = 1. rd_data and rd_valid are 0 after reset.
- R3: With op_state = 1 (program), bit 7 reads the inverse of bit 7 of prog_data, and bits 3 and 2 read 0.
- R4: Bit 6 reads 0 on the first read after an op_start pulse. It then inverts on each further read in states 1 to 4 (program, chip erase, sector accumulation window, sector erase).
- R5: In states 1 to 4, bit 5 reads the time_over input. While time_over is 1, reads do not advance bit 6 or bit 2.
- R6: In the erase states, bit 7 reads 0. Bit 3 reads 0 in state 3 (accumulation window) and 1 in state 4 (sector erase) and state 2 (chip erase).
- R7: Bit 2 reads 0 in state 1. In states 2 to 4 it starts at 0 after op_start and inverts on each read.
- R8: In state 5 (suspend), a read from a sector whose erase_mask bit is set returns bits 7:3 = 00001 and a bit 2 that inverts on each such read. The sector is the top SECT_BITS bits of rd_addr.
- R9: In state 5, a read from a sector whose erase_mask bit is clear returns the array word unchanged and leaves bit 2 as it was.
- R10: rd_unsure is 1 on the first read result after a cmd_wr pulse, including a read in the same cycle as cmd_wr, and 0 on later reads.
- R11: op_start clears both toggle bits. A read in the same cycle as op_start still sees the old toggle values.
- R12: Cycles with no read strobe leave both toggle bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | 0 idle, 1 program, 2 chip erase, 3 accumulation window, 4 sector erase, 5 suspend |
| op_start | input | 1 | One-cycle pulse when an operation begins |
| cmd_wr | input | 1 | One-cycle pulse on each command write |
| time_over | input | 1 | Operation has exceeded its time limit |
| prog_data | input | DATA_W | Half-word being programmed |
| erase_mask | input | NSECT | One bit per sector chosen for erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array word at rd_addr |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | rd_data holds a new result |
| rd_unsure | output | 1 | This result follows a command write and is not guaranteed |

## Verification
Two events can land in the same cycle, and the bench forces both. First, a read strobe can coincide with op_start. The bench expects that read to show the toggle values from before the start, and the next read to show zeros. Second, a read strobe can coincide with a command write. The bench expects that read to carry the unsure marker and the following read to be clean. A scoreboard model predicts each case from the requirements and compares the registered result one cycle after the strobe.

// File: rtl/flashstat_pkg.sv
package flashstat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SWIN   = 3'd3,
        OP_SERASE = 3'd4,
        OP_SUSP   = 3'd5
    } op_e;

    typedef struct packed {
        logic dpoll;
        logic tog;
        logic tlim;
        logic rsv4;
        logic etimer;
        logic tog2;
        logic rsv1;
        logic rsv0;
    } stat_t;

    function automatic logic op_busy(op_e s);
        return (s == OP_PROG) || (s == OP_CHIP) || (s == OP_SWIN) || (s == OP_SERASE);
    endfunction

    function automatic logic op_erasing(op_e s);
        return (s == OP_CHIP) || (s == OP_SWIN) || (s == OP_SERASE);
    endfunction

endpackage

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
    parameter int ADDR_W    = 17,
    parameter int SECT_BITS = 2,
    localparam int NSECT    = 1 << SECT_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  mask,
    output logic              hit
);
    logic [SECT_BITS-1:0] idx;
    logic [NSECT-1:0]     sel;

    assign idx = addr[ADDR_W-1 -: SECT_BITS];

    for (genvar g = 0; g < NSECT; g++) begin : g_dec
        assign sel[g] = (idx == SECT_BITS'(g)) && mask[g];
    end

    assign hit = |sel;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic adv_main,
    input  logic adv_aux,
    output logic tog_main,
    output logic tog_aux
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tog_main <= 1'b0;
            tog_aux  <= 1'b0;
        end else begin
            if (adv_main) tog_main <= ~tog_main;
            if (adv_aux)  tog_aux  <= ~tog_aux;
        end
    end
endmodule

// File: rtl/fsg_first_read.sv
module fsg_first_read (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic rd_en,
    output logic unsure_now
);
    logic pending;

    assign unsure_now = rd_en && (pending || cmd_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (rd_en) begin
            pending <= 1'b0;
        end else if (cmd_wr) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/fsg_compose.sv
module fsg_compose
    import flashstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               st,
    input  logic              time_over,
    input  logic              pd_msb,
    input  logic              tgt,
    input  logic              tog,
    input  logic              tog2,
    input  logic [DATA_W-1:0] arr,
    output logic [DATA_W-1:0] word
);
    stat_t s;
    logic  pass;

    always_comb begin
        s    = '0;
        pass = 1'b0;
        unique case (st)
            OP_PROG: begin
                s.dpoll = ~pd_msb;
                s.tog   = tog;
                s.tlim  = time_over;
            end
            OP_CHIP, OP_SERASE: begin
                s.tog    = tog;
                s.tlim   = time_over;
                s.etimer = 1'b1;
                s.tog2   = tog2;
            end
            OP_SWIN: begin
                s.tog  = tog;
                s.tlim = time_over;
                s.tog2 = tog2;
            end
            OP_SUSP: begin
                if (tgt) begin
                    s.etimer = 1'b1;
                    s.tog2   = tog2;
                end else begin
                    pass = 1'b1;
                end
            end
            default: pass = 1'b1;
        endcase
    end

    assign word = pass ? arr : {{(DATA_W-8){1'b0}}, s};
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flashstat_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 17,
    parameter int SECT_BITS = 2,
    localparam int NSECT    = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_state,
    input  logic              op_start,
    input  logic              cmd_wr,
    input  logic              time_over,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_unsure
);
    op_e               st;
    logic              tgt;
    logic              tog, tog2;
    logic              adv_main, adv_aux;
    logic              unsure_now;
    logic [DATA_W-1:0] word;

    assign st = op_e'(op_state);

    fsg_sector_hit #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_hit (
        .addr (rd_addr),
        .mask (erase_mask),
        .hit  (tgt)
    );

    // toggles move only on accepted reads; a time-limit stall freezes them
    assign adv_main = rd_en && op_busy(st) && !time_over;
    assign adv_aux  = rd_en && ((op_erasing(st) && !time_over) || (st == OP_SUSP && tgt));

    fsg_toggle u_tog (
        .clk      (clk),
        .rst      (rst),
        .clear    (op_start),
        .adv_main (adv_main),
        .adv_aux  (adv_aux),
        .tog_main (tog),
        .tog_aux  (tog2)
    );

    fsg_first_read u_first (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .rd_en      (rd_en),
        .unsure_now (unsure_now)
    );

    fsg_compose #(.DATA_W(DATA_W)) u_comp (
        .st        (st),
        .time_over (time_over),
        .pd_msb    (prog_data[7]),
        .tgt       (tgt),
        .tog       (tog),
        .tog2      (tog2),
        .arr       (arr_data),
        .word      (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            rd_unsure <= 1'b0;
        end else begin
            rd_valid  <= rd_en;
            rd_unsure <= unsure_now;
            if (rd_en) rd_data <= word;
        end
    end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 17,
    parameter int SECT_BITS = 2,
    localparam int NSECT    = 1 << SECT_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_state,
    input logic              time_over,
    input logic [DATA_W-1:0] prog_data,
    input logic [NSECT-1:0]  erase_mask,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_unsure
);
    logic in_tgt;
    logic busy;
    assign in_tgt = erase_mask[rd_addr[ADDR_W-1 -: SECT_BITS]];
    assign busy   = (op_state >= 3'd1) && (op_state <= 3'd4);

    AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid) else $error("valid missing"); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid) else $error("spurious valid"); // R2
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (rd_en && op_state == 3'd0) |=> rd_data == $past(arr_data)) else $error("idle data"); // R1
    AST_PROG_DPOLL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && op_state == 3'd1) |=> (rd_data[7] == !$past(prog_data[7]) && rd_data[3:2] == 2'b00))
        else $error("program flags"); // R3
    AST_TLIM_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> rd_data[5] == $past(time_over)) else $error("time limit bit"); // R5
    AST_SUSP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (rd_en && op_state == 3'd5 && in_tgt) |=> rd_data[7:3] == 5'b00001) else $error("suspend target"); // R8
    AST_UNSURE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_unsure |-> rd_valid) else $error("unsure without read"); // R10
endmodule

bind flash_status_gen flash_status_gen_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)
) u_chk (
    .clk(clk), .rst(rst), .op_state(op_state), .time_over(time_over),
    .prog_data(prog_data), .erase_mask(erase_mask), .rd_en(rd_en),
    .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_unsure(rd_unsure)
);

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
    localparam int DW = 16;
    localparam int AW = 17;
    localparam int SB = 2;
    localparam int NS = 1 << SB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_state = 3'd0;
    logic          op_start = 1'b0, cmd_wr = 1'b0, time_over = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] prog_data = '0, arr_data = '0;
    logic [NS-1:0] erase_mask = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_unsure;

    always #2 clk = ~clk;

    flash_status_gen uut (
        .clk(clk), .rst(rst), .op_state(op_state), .op_start(op_start),
        .cmd_wr(cmd_wr), .time_over(time_over), .prog_data(prog_data),
        .erase_mask(erase_mask), .rd_en(rd_en), .rd_addr(rd_addr),
        .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_unsure(rd_unsure)
    );

    typedef struct {
        logic [DW-1:0] d;
        logic          u;
        string         tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    logic m_tog = 0, m_tog2 = 0, m_pend = 0;
    bit   done = 0;

    function automatic logic [DW-1:0] model_word(logic [AW-1:0] a, logic [DW-1:0] arr);
        logic t;
        t = erase_mask[a[AW-1 -: SB]];
        case (op_state)
            3'd1: return {8'h00, ~prog_data[7], m_tog, time_over, 5'b00000};
            3'd2, 3'd4: return {8'h00, 1'b0, m_tog, time_over, 1'b0, 1'b1, m_tog2, 2'b00};
            3'd3: return {8'h00, 1'b0, m_tog, time_over, 1'b0, 1'b0, m_tog2, 2'b00};
            3'd5: return t ? {8'h00, 5'b00001, m_tog2, 2'b00} : arr;
            default: return arr;
        endcase
    endfunction

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, input string tag,
                      input logic with_start = 0, input logic with_cmd = 0);
        exp_t e;
        logic busy, ers, t;
        rd_addr = a; arr_data = arr; rd_en = 1'b1;
        op_start = with_start; cmd_wr = with_cmd;
        e.d = model_word(a, arr);
        e.u = m_pend || with_cmd;
        e.tag = tag;
        q.push_back(e);
        busy = (op_state >= 3'd1) && (op_state <= 3'd4);
        ers  = (op_state >= 3'd2) && (op_state <= 3'd4);
        t    = erase_mask[a[AW-1 -: SB]];
        if (busy && !time_over) m_tog = ~m_tog;
        if ((ers && !time_over) || (op_state == 3'd5 && t)) m_tog2 = ~m_tog2;
        if (with_start) begin m_tog = 0; m_tog2 = 0; end
        m_pend = 0;
        @(negedge clk);
        rd_en = 1'b0; op_start = 1'b0; cmd_wr = 1'b0;
    endtask

    task automatic cmd();
        cmd_wr = 1'b1; m_pend = 1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic set_op(input logic [2:0] s, input logic start);
        op_state = s; op_start = start;
        if (start) begin m_tog = 0; m_tog2 = 0; end
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: compare each registered result against the queued prediction
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2: result with no pending read, got %h expected none", rd_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rd_data !== e.d || rd_unsure !== e.u) begin
                    fails++;
                    $display("FAIL %s: data %h unsure %b, expected data %h unsure %b",
                             e.tag, rd_data, rd_unsure, e.d, e.u);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0 || rd_unsure !== 1'b0) begin
            fails++;
            $display("FAIL R2: reset outputs %b/%h/%b expected 0/0000/0", rd_valid, rd_data, rd_unsure);
        end

        // idle passthrough
        rd(17'h00010, 16'hBEEF, "R1");
        rd(17'h1FFFE, 16'h1234, "R1");

        // program: data bit7 = 1, first read after command is unsure
        prog_data = 16'h5A80;
        cmd();
        set_op(3'd1, 1'b1);
        rd(17'h00100, 16'hFFFF, "R10");
        rd(17'h00100, 16'hFFFF, "R4");
        rd(17'h00102, 16'hFFFF, "R3");
        idle(3);
        rd(17'h00104, 16'h0000, "R12");
        rd(17'h00104, 16'h0000, "R4");
        // time limit: bit 5 set, toggle frozen
        time_over = 1'b1;
        rd(17'h00104, 16'h0000, "R5");
        rd(17'h00104, 16'h0000, "R5");
        time_over = 1'b0;
        prog_data = 16'h007F;
        rd(17'h00104, 16'h0000, "R3");

        // sector erase, sector 1 targeted
        erase_mask = 4'b0010;
        cmd();
        set_op(3'd3, 1'b1);
        rd(17'h08000, 16'hFFFF, "R6");
        rd(17'h08000, 16'hFFFF, "R7");
        rd(17'h00000, 16'hFFFF, "R7");
        set_op(3'd4, 1'b0);
        rd(17'h08000, 16'hFFFF, "R6");
        rd(17'h10000, 16'hFFFF, "R7");
        idle(2);
        rd(17'h10000, 16'hFFFF, "R12");

        // suspend: target vs non-target
        set_op(3'd5, 1'b0);
        rd(17'h08002, 16'h1111, "R8");
        rd(17'h10000, 16'hA5C3, "R9");
        rd(17'h08004, 16'h2222, "R8");
        rd(17'h18000, 16'h3C3C, "R9");
        time_over = 1'b1;
        rd(17'h08004, 16'h2222, "R8");
        time_over = 1'b0;
        set_op(3'd4, 1'b0);
        rd(17'h08000, 16'hFFFF, "R6");

        // chip erase with time limit reached partway
        erase_mask = 4'b1111;
        cmd();
        set_op(3'd2, 1'b1);
        rd(17'h00000, 16'hFFFF, "R10");
        rd(17'h00000, 16'hFFFF, "R6");
        rd(17'h00000, 16'hFFFF, "R7");
        time_over = 1'b1;
        rd(17'h00000, 16'hFFFF, "R5");
        rd(17'h00000, 16'hFFFF, "R5");
        time_over = 1'b0;

        // same-cycle events
        rd(17'h00000, 16'hFFFF, "R11", 1'b1, 1'b0);
        rd(17'h00000, 16'hFFFF, "R11");
        rd(17'h00000, 16'hFFFF, "R4");
        rd(17'h00000, 16'hFFFF, "R10", 1'b0, 1'b1);
        rd(17'h00000, 16'hFFFF, "R10");

        // back to idle
        set_op(3'd0, 1'b0);
        rd(17'h04000, 16'hC0DE, "R1");
        rd(17'h04002, 16'h8001, "R1");

        idle(3);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule